// File: doc/BRIEF.md
# Dual-interface memory access arbiter

This block decides which of two ports may reach a shared memory made of a non-volatile user array, a small SRAM and a set of status registers. One port carries contactless RF commands and the other carries I2C target transfers. Each port raises a request with an address. In the same cycle the arbiter answers with a grant or a refusal, plus a region code that says which memory the address resolves to. A memory grant takes a per-port lock if the opposite port holds none, so the first requester wins. Status registers are reachable from either side at any time and never touch the locks.

A 2-bit mode input selects the scheme. The modes are plain, SRAM mirror, pass-through and health-device. The mode, the supply and field qualifiers and the SRAM enable together decide where the SRAM appears in each port's address map, and whether it overlays the low user blocks. Each lock has its own release events. In health-device mode an RF SRAM request can take over an I2C SRAM transfer at a byte boundary. The I2C side is held by clock stretching until the RF command completes, and then it gets its lock back. A programmable down-counting watchdog frees a stale I2C lock.

Top module: `dual_port_mem_arbiter`

## Requirements
- R1: SRAM is reachable only when vcc_ok=1 and sram_en=1. For mode values 01, 10 and 11, field_ok=1 is also needed. In any other case an SRAM-window address or an RF SRAM command is refused with region 0, and the RF blocks 00h-3Fh fall back to the user array (region 1).
- R2: A granted memory access (region 1 or 2) sets the requester's lock only if the other port holds no lock. While one port is locked, the other port's memory requests are refused and its lock stays clear.
- R3: If both ports request memory in the same cycle and no lock is held, the RF port is granted and locked, and the I2C request is refused.
- R4: A status request (region 3) is granted in the same cycle whatever the lock state, and it changes neither lock.
- R5: The I2C lock clears one edge after i2c_clr_lock=1, or one edge after vcc_ok=0.
- R6: With wdg_en=0, i2c_txn_end=1 clears the I2C lock on the next edge. With wdg_en=1, i2c_txn_end has no effect on the lock.
- R7: With wdg_en=1, every granted I2C memory access reloads the watchdog with wdg_limit. After that reload edge, wdg_fire pulses for one cycle after exactly wdg_limit further edges while the I2C lock is held, and the lock is clear after the next edge.
- R8: The RF lock clears one edge after rf_done=1, or one edge after field_ok=0.
- R9: In plain mode (00) the I2C addresses 2000h-201Fh map to SRAM and 2020h-203Fh are refused. The RF block addresses always map to the user array, and an RF SRAM command maps to SRAM.
- R10: In mirror mode (01) and health mode (11) the block addresses 00h-3Fh map to SRAM on both ports, and block 40h and above map to the user array. The I2C addresses 2000h-203Fh also map to SRAM.
- R11: In pass-through mode (10) the SRAM appears only at I2C 2000h-203Fh and through RF SRAM commands. Blocks 00h-3Fh map to the user array on both ports.
- R12: In health mode, an RF SRAM request made while the I2C side is locked inside an SRAM transfer gets neither grant nor refusal until i2c_byte_done=1. On the next edge the locks swap (rf_locked=1, i2c_locked=0) and i2c_stretch=1. After rf_done, the locks swap back and i2c_stretch=0. In any other mode the same request is refused.
- R13: An I2C address at or above the end of the SRAM window (2040h and up, or 2020h and up in plain mode) is refused with region 0.

Region codes: 0 = invalid, 1 = user array, 2 = SRAM, 3 = status registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset, acts as power-on reset |
| mode | input | 2 | Scheme: 00 plain, 01 mirror, 10 pass-through, 11 health |
| sram_en | input | 1 | SRAM enable configuration bit |
| vcc_ok | input | 1 | Wired supply present (I2C side powered) |
| field_ok | input | 1 | RF field present |
| wdg_en | input | 1 | Watchdog enable |
| wdg_limit | input | WDG_W | Watchdog reload value in cycles |
| rf_req | input | 1 | RF access request, held until answered |
| rf_status | input | 1 | RF request targets status registers |
| rf_sram_cmd | input | 1 | RF request is a dedicated SRAM command |
| rf_blk | input | BLK_W | RF block address |
| rf_done | input | 1 | Current RF command completed |
| rf_grant | output | 1 | RF request granted |
| rf_refuse | output | 1 | RF request refused |
| rf_region | output | 2 | Region the RF request resolves to |
| i2c_req | input | 1 | I2C access request |
| i2c_status | input | 1 | I2C request targets status registers |
| i2c_addr | input | ADDR_W | I2C memory address |
| i2c_clr_lock | input | 1 | Host write clearing the I2C lock |
| i2c_txn_end | input | 1 | I2C transaction ended (stop) |
| i2c_byte_done | input | 1 | I2C byte boundary reached |
| i2c_grant | output | 1 | I2C request granted |
| i2c_refuse | output | 1 | I2C request refused (data NAK) |
| i2c_region | output | 2 | Region the I2C request resolves to |
| rf_locked | output | 1 | RF side holds the memory lock |
| i2c_locked | output | 1 | I2C side holds the memory lock |
| i2c_stretch | output | 1 | I2C clock held while the RF side has taken over |
| wdg_fire | output | 1 | One-cycle watchdog expiry pulse |

## Verification
Two pairs of functions can meet in one cycle. The first is the two ports' memory requests. The bench raises both in the same cycle with no lock held and judges the result: the RF grant and the I2C refusal must appear together, and after the edge only the RF lock may be set. The second is the health-mode takeover against the I2C byte boundary. The bench holds an RF SRAM request across an I2C SRAM lock and checks that the request stays unanswered until i2c_byte_done. It then checks that the lock swap, the stretch and the grant all appear after that one edge, and that the release on rf_done restores the I2C lock.

// File: rtl/arb_pkg.sv
// Shared types for the dual-interface memory arbiter.
// Assumes: mode and region encodings are fixed at 2 bits.
package arb_pkg;
    typedef enum logic [1:0] {
        MODE_PLAIN  = 2'b00,
        MODE_MIRROR = 2'b01,
        MODE_PASS   = 2'b10,
        MODE_HEALTH = 2'b11
    } arb_mode_e;

    typedef enum logic [1:0] {
        RGN_NONE = 2'd0,
        RGN_NVM  = 2'd1,
        RGN_SRAM = 2'd2,
        RGN_STAT = 2'd3
    } arb_rgn_e;
endpackage

// File: rtl/arb_addr_map.sv
// Address decoder: resolves each port's request to a memory region from
// the mode and the SRAM qualifier. Purely combinational.
// Assumes: the I2C SRAM window starts at SRAM_BASE, above the user array.
module arb_addr_map
    import arb_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int BLK_W      = 8,
    parameter int SRAM_BASE  = 'h2000,
    parameter int SPAN_PLAIN = 32,
    parameter int SPAN_FULL  = 64,
    parameter int OVL_BLOCKS = 64
) (
    input  arb_mode_e         mode,
    input  logic              sram_ok,
    input  logic              rf_status,
    input  logic              rf_sram_cmd,
    input  logic [BLK_W-1:0]  rf_blk,
    input  logic              i2c_status,
    input  logic [ADDR_W-1:0] i2c_addr,
    output arb_rgn_e          rf_rgn,
    output arb_rgn_e          i2c_rgn
);
    localparam logic [ADDR_W-1:0] WIN_LO     = ADDR_W'(SRAM_BASE);
    localparam logic [ADDR_W-1:0] WIN_HI_PL  = ADDR_W'(SRAM_BASE + SPAN_PLAIN);
    localparam logic [ADDR_W-1:0] WIN_HI_FL  = ADDR_W'(SRAM_BASE + SPAN_FULL);
    localparam logic [ADDR_W-1:0] OVL_TOP_A  = ADDR_W'(OVL_BLOCKS);
    localparam logic [BLK_W-1:0]  OVL_TOP_B  = BLK_W'(OVL_BLOCKS);

    logic              overlay;
    logic [ADDR_W-1:0] win_hi;
    logic              in_win;

    // Overlay of low user blocks and the size of the I2C SRAM window
    always_comb begin
        overlay = sram_ok && (mode == MODE_MIRROR || mode == MODE_HEALTH);
        win_hi  = (mode == MODE_PLAIN) ? WIN_HI_PL : WIN_HI_FL;
        in_win  = (i2c_addr >= WIN_LO) && (i2c_addr < win_hi);
    end

    // RF side decode
    always_comb begin
        if (rf_status)                         rf_rgn = RGN_STAT;
        else if (rf_sram_cmd)                  rf_rgn = sram_ok ? RGN_SRAM : RGN_NONE;
        else if (overlay && rf_blk < OVL_TOP_B) rf_rgn = RGN_SRAM;
        else                                   rf_rgn = RGN_NVM;
    end

    // I2C side decode
    always_comb begin
        if (i2c_status)                           i2c_rgn = RGN_STAT;
        else if (in_win)                          i2c_rgn = sram_ok ? RGN_SRAM : RGN_NONE;
        else if (i2c_addr < WIN_LO)
            i2c_rgn = (overlay && i2c_addr < OVL_TOP_A) ? RGN_SRAM : RGN_NVM;
        else                                      i2c_rgn = RGN_NONE;
    end

    // R1
    always_comb begin
        sram_gate_chk: assert (!((rf_rgn == RGN_SRAM || i2c_rgn == RGN_SRAM) && !sram_ok));
    end
endmodule

// File: rtl/arb_i2c_wdog.sv
// I2C lock watchdog: a down-counter reloaded on each granted I2C memory
// access. It counts while running and pulses fire when it sits at zero.
// Assumes: the caller drops run on the cycle after fire (lock released).
module arb_i2c_wdog #(
    parameter int WDG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             reload,
    input  logic [WDG_W-1:0] limit,
    output logic             fire
);
    logic [WDG_W-1:0] cnt;

    // Reload, count down while running, hold at zero
    always_ff @(posedge clk) begin
        if (!rst_n)                  cnt <= '0;
        else if (reload)             cnt <= limit;
        else if (run && cnt != '0)   cnt <= cnt - 1'b1;
    end

    // Expiry flag while running at zero
    always_comb fire = run && (cnt == '0);
endmodule

// File: rtl/arb_lock_ctrl.sv
// Lock controller: holds one lock per port, grants first come first served
// (RF wins a tie), and answers requests with grant or refuse. It applies each
// lock's release events and handles the health-mode RF takeover of an I2C
// SRAM transfer at a byte boundary.
// Assumes: requests are held by the port until grant or refuse is seen.
module arb_lock_ctrl
    import arb_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  arb_mode_e mode,
    input  logic      vcc_ok,
    input  logic      field_ok,
    input  logic      wdg_en,
    input  logic      wdg_fire,
    input  logic      rf_req,
    input  arb_rgn_e  rf_rgn,
    input  logic      rf_done,
    input  logic      i2c_req,
    input  arb_rgn_e  i2c_rgn,
    input  logic      i2c_clr_lock,
    input  logic      i2c_txn_end,
    input  logic      i2c_byte_done,
    output logic      rf_grant,
    output logic      rf_refuse,
    output logic      i2c_grant,
    output logic      i2c_refuse,
    output logic      rf_locked,
    output logic      i2c_locked,
    output logic      i2c_stretch,
    output logic      i2c_mem_win
);
    logic rf_mem, rf_stat, rf_bad, i2c_mem, i2c_stat, i2c_bad;
    logic rf_win, preempt, swap, rf_rel, i2c_rel;
    logic parked, in_sram;

    // Classify requests by region
    always_comb begin
        rf_mem   = rf_req  && (rf_rgn  == RGN_NVM || rf_rgn  == RGN_SRAM);
        rf_stat  = rf_req  && (rf_rgn  == RGN_STAT);
        rf_bad   = rf_req  && (rf_rgn  == RGN_NONE);
        i2c_mem  = i2c_req && (i2c_rgn == RGN_NVM || i2c_rgn == RGN_SRAM);
        i2c_stat = i2c_req && (i2c_rgn == RGN_STAT);
        i2c_bad  = i2c_req && (i2c_rgn == RGN_NONE);
    end

    // Arbitration: RF first on a tie, health-mode takeover waits for a byte edge
    always_comb begin
        rf_win      = rf_mem && !i2c_locked;
        preempt     = (mode == MODE_HEALTH) && i2c_locked && in_sram
                      && rf_mem && (rf_rgn == RGN_SRAM);
        swap        = preempt && i2c_byte_done;
        i2c_mem_win = i2c_mem && !rf_locked && !rf_win;
        rf_grant    = rf_stat || rf_win;
        rf_refuse   = rf_bad  || (rf_mem && i2c_locked && !preempt);
        i2c_grant   = i2c_stat || i2c_mem_win;
        i2c_refuse  = i2c_bad  || (i2c_mem && !i2c_mem_win);
        rf_rel      = rf_done || !field_ok;
        i2c_rel     = i2c_clr_lock || wdg_fire || !vcc_ok || (i2c_txn_end && !wdg_en);
        i2c_stretch = parked;
    end

    // RF lock: release dominates, set by a win or a takeover
    always_ff @(posedge clk) begin
        if (!rst_n)               rf_locked <= 1'b0;
        else if (rf_rel)          rf_locked <= 1'b0;
        else if (swap || rf_win)  rf_locked <= 1'b1;
    end

    // Parked flag: I2C transfer suspended during an RF takeover
    always_ff @(posedge clk) begin
        if (!rst_n)                 parked <= 1'b0;
        else if (parked && rf_rel)  parked <= 1'b0;
        else if (swap)              parked <= 1'b1;
    end

    // I2C lock: handed over on a takeover, restored afterwards, else release or win
    always_ff @(posedge clk) begin
        if (!rst_n)                            i2c_locked <= 1'b0;
        else if (swap)                         i2c_locked <= 1'b0;
        else if (parked && rf_rel && vcc_ok)   i2c_locked <= 1'b1;
        else if (i2c_rel)                      i2c_locked <= 1'b0;
        else if (i2c_mem_win)                  i2c_locked <= 1'b1;
    end

    // Tracks whether the I2C lock holder is inside an SRAM transfer
    always_ff @(posedge clk) begin
        if (!rst_n)                              in_sram <= 1'b0;
        else if (i2c_mem_win)                    in_sram <= (i2c_rgn == RGN_SRAM);
        else if (!parked && (i2c_rel || i2c_txn_end)) in_sram <= 1'b0;
    end

    // R2
    locks_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rf_locked && i2c_locked));
    // R8
    rf_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_done || !field_ok) |=> !rf_locked);
    // R5
    vcc_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !vcc_ok |=> !i2c_locked);
    // R6
    txn_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (i2c_txn_end && !wdg_en && !i2c_stretch) |=> !i2c_locked);
    // R7
    wdg_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wdg_fire && !i2c_stretch) |=> !i2c_locked);
    // R12
    stretch_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        i2c_stretch |-> (rf_locked && !i2c_locked));
endmodule

// File: rtl/dual_port_mem_arbiter.sv
// Top of the dual-interface memory arbiter. It forms the SRAM qualifier from
// the supply, field, enable and mode inputs, decodes both ports' addresses,
// and drives the lock controller and the I2C watchdog.
// Assumes: rst_n is synchronous and serves as power-on reset.
module dual_port_mem_arbiter
    import arb_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int BLK_W      = 8,
    parameter int WDG_W      = 8,
    parameter int SRAM_BASE  = 'h2000,
    parameter int SPAN_PLAIN = 32,
    parameter int SPAN_FULL  = 64,
    parameter int OVL_BLOCKS = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode,
    input  logic              sram_en,
    input  logic              vcc_ok,
    input  logic              field_ok,
    input  logic              wdg_en,
    input  logic [WDG_W-1:0]  wdg_limit,
    input  logic              rf_req,
    input  logic              rf_status,
    input  logic              rf_sram_cmd,
    input  logic [BLK_W-1:0]  rf_blk,
    input  logic              rf_done,
    output logic              rf_grant,
    output logic              rf_refuse,
    output logic [1:0]        rf_region,
    input  logic              i2c_req,
    input  logic              i2c_status,
    input  logic [ADDR_W-1:0] i2c_addr,
    input  logic              i2c_clr_lock,
    input  logic              i2c_txn_end,
    input  logic              i2c_byte_done,
    output logic              i2c_grant,
    output logic              i2c_refuse,
    output logic [1:0]        i2c_region,
    output logic              rf_locked,
    output logic              i2c_locked,
    output logic              i2c_stretch,
    output logic              wdg_fire
);
    arb_mode_e mode_e;
    arb_rgn_e  rf_rgn, i2c_rgn;
    logic      sram_ok, mem_win, wdg_run;

    // SRAM qualifier: wired supply and enable, plus field outside plain mode
    always_comb begin
        mode_e     = arb_mode_e'(mode);
        sram_ok    = vcc_ok && sram_en && (mode_e == MODE_PLAIN || field_ok);
        rf_region  = rf_rgn;
        i2c_region = i2c_rgn;
        wdg_run    = i2c_locked && wdg_en;
    end

    arb_addr_map #(
        .ADDR_W(ADDR_W), .BLK_W(BLK_W), .SRAM_BASE(SRAM_BASE),
        .SPAN_PLAIN(SPAN_PLAIN), .SPAN_FULL(SPAN_FULL), .OVL_BLOCKS(OVL_BLOCKS)
    ) u_map (
        .mode(mode_e), .sram_ok(sram_ok),
        .rf_status(rf_status), .rf_sram_cmd(rf_sram_cmd), .rf_blk(rf_blk),
        .i2c_status(i2c_status), .i2c_addr(i2c_addr),
        .rf_rgn(rf_rgn), .i2c_rgn(i2c_rgn)
    );

    arb_lock_ctrl u_lock (
        .clk(clk), .rst_n(rst_n), .mode(mode_e),
        .vcc_ok(vcc_ok), .field_ok(field_ok), .wdg_en(wdg_en), .wdg_fire(wdg_fire),
        .rf_req(rf_req), .rf_rgn(rf_rgn), .rf_done(rf_done),
        .i2c_req(i2c_req), .i2c_rgn(i2c_rgn), .i2c_clr_lock(i2c_clr_lock),
        .i2c_txn_end(i2c_txn_end), .i2c_byte_done(i2c_byte_done),
        .rf_grant(rf_grant), .rf_refuse(rf_refuse),
        .i2c_grant(i2c_grant), .i2c_refuse(i2c_refuse),
        .rf_locked(rf_locked), .i2c_locked(i2c_locked),
        .i2c_stretch(i2c_stretch), .i2c_mem_win(mem_win)
    );

    arb_i2c_wdog #(.WDG_W(WDG_W)) u_wdog (
        .clk(clk), .rst_n(rst_n), .run(wdg_run), .reload(mem_win),
        .limit(wdg_limit), .fire(wdg_fire)
    );
endmodule

// File: tb/dual_port_mem_arbiter_tb.sv
// Bench: a vector table for the address maps and qualifiers, then directed
// tests for reset, locking, ties, releases, the watchdog and the takeover.
module dual_port_mem_arbiter_tb;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n = 1'b0;
    logic [1:0] mode = 2'b00;
    logic sram_en = 1'b1, vcc_ok = 1'b1, field_ok = 1'b1, wdg_en = 1'b0;
    logic [7:0] wdg_limit = 8'd200;
    logic rf_req = 0, rf_status = 0, rf_sram_cmd = 0, rf_done = 0;
    logic [7:0] rf_blk = 8'h00;
    logic i2c_req = 0, i2c_status = 0, i2c_clr_lock = 0, i2c_txn_end = 0, i2c_byte_done = 0;
    logic [15:0] i2c_addr = 16'h0000;
    logic rf_grant, rf_refuse, i2c_grant, i2c_refuse;
    logic [1:0] rf_region, i2c_region;
    logic rf_locked, i2c_locked, i2c_stretch, wdg_fire;

    int checks = 0;
    int failures = 0;

    dual_port_mem_arbiter u_dut (
        .clk(clk), .rst_n(rst_n), .mode(mode), .sram_en(sram_en), .vcc_ok(vcc_ok),
        .field_ok(field_ok), .wdg_en(wdg_en), .wdg_limit(wdg_limit),
        .rf_req(rf_req), .rf_status(rf_status), .rf_sram_cmd(rf_sram_cmd),
        .rf_blk(rf_blk), .rf_done(rf_done), .rf_grant(rf_grant),
        .rf_refuse(rf_refuse), .rf_region(rf_region),
        .i2c_req(i2c_req), .i2c_status(i2c_status), .i2c_addr(i2c_addr),
        .i2c_clr_lock(i2c_clr_lock), .i2c_txn_end(i2c_txn_end),
        .i2c_byte_done(i2c_byte_done), .i2c_grant(i2c_grant),
        .i2c_refuse(i2c_refuse), .i2c_region(i2c_region),
        .rf_locked(rf_locked), .i2c_locked(i2c_locked),
        .i2c_stretch(i2c_stretch), .wdg_fire(wdg_fire)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One clock edge; inputs change 2 ns after it
    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    // Pulse both lock releases with no request active
    task automatic release_all();
        rf_req = 0; i2c_req = 0; rf_sram_cmd = 0; rf_status = 0; i2c_status = 0;
        rf_done = 1; i2c_clr_lock = 1;
        tick();
        rf_done = 0; i2c_clr_lock = 0;
    endtask

    typedef struct packed {
        logic [1:0]  md;
        logic        en, vcc, fld, is_rf, st, cmd;
        logic [15:0] adr;
        logic        g, r;
        logic [1:0]  rgn;
        logic [7:0]  tag;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{2'b00,1,1,1,0,0,0,16'h2000,1,0,2'd2,8'd9},   // R9 plain window start
        '{2'b00,1,1,1,0,0,0,16'h201F,1,0,2'd2,8'd9},   // R9 plain window end
        '{2'b00,1,1,1,0,0,0,16'h2020,0,1,2'd0,8'd9},   // R9 beyond plain window
        '{2'b00,1,1,1,1,0,0,16'h0005,1,0,2'd1,8'd9},   // R9 RF block is user array
        '{2'b00,1,1,1,1,0,1,16'h0000,1,0,2'd2,8'd9},   // R9 RF SRAM command
        '{2'b00,0,1,1,1,0,1,16'h0000,0,1,2'd0,8'd1},   // R1 enable off
        '{2'b00,1,0,1,0,0,0,16'h2000,0,1,2'd0,8'd1},   // R1 no wired supply
        '{2'b01,1,1,1,1,0,0,16'h003F,1,0,2'd2,8'd10},  // R10 last overlay block
        '{2'b01,1,1,1,1,0,0,16'h0040,1,0,2'd1,8'd10},  // R10 above overlay
        '{2'b01,1,1,1,0,0,0,16'h0010,1,0,2'd2,8'd10},  // R10 I2C overlay
        '{2'b01,1,1,1,0,0,0,16'h203F,1,0,2'd2,8'd10},  // R10 full window end
        '{2'b01,1,1,0,1,0,0,16'h0000,1,0,2'd1,8'd1},   // R1 no field: no overlay
        '{2'b01,1,1,0,0,0,0,16'h2000,0,1,2'd0,8'd1},   // R1 no field: window off
        '{2'b10,1,1,1,0,0,0,16'h0000,1,0,2'd1,8'd11},  // R11 I2C block 0 user array
        '{2'b10,1,1,1,1,0,0,16'h0000,1,0,2'd1,8'd11},  // R11 RF block 0 user array
        '{2'b10,1,1,1,0,0,0,16'h2030,1,0,2'd2,8'd11},  // R11 window in pass mode
        '{2'b11,1,1,1,0,0,0,16'h0020,1,0,2'd2,8'd10},  // R10 health overlay
        '{2'b00,1,1,1,0,0,0,16'h2040,0,1,2'd0,8'd13},  // R13 above window
        '{2'b10,1,1,1,0,0,0,16'h8000,0,1,2'd0,8'd13},  // R13 far address
        '{2'b00,1,1,1,1,1,0,16'h0000,1,0,2'd3,8'd4}    // R4 status access
    };

    initial begin
        #1500000;
        failures++;
        $display("FAIL watchdog timeout actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        tick(); tick(); tick();
        // Reset state
        check("R2 reset rf_locked", rf_locked, 0);
        check("R2 reset i2c_locked", i2c_locked, 0);
        check("R12 reset stretch", i2c_stretch, 0);
        check("R7 reset fire", wdg_fire, 0);
        rst_n = 1;
        tick();

        // Vector table: decode and qualifiers
        for (int i = 0; i < NV; i++) begin
            string tg;
            tg = $sformatf("R%0d vec%0d", VECS[i].tag, i);
            mode = VECS[i].md; sram_en = VECS[i].en; vcc_ok = VECS[i].vcc;
            field_ok = VECS[i].fld;
            if (VECS[i].is_rf) begin
                rf_req = 1; rf_status = VECS[i].st; rf_sram_cmd = VECS[i].cmd;
                rf_blk = VECS[i].adr[7:0];
                #5;
                check({tg, " grant"}, rf_grant, VECS[i].g);
                check({tg, " refuse"}, rf_refuse, VECS[i].r);
                check({tg, " region"}, rf_region, VECS[i].rgn);
            end else begin
                i2c_req = 1; i2c_status = VECS[i].st; i2c_addr = VECS[i].adr;
                #5;
                check({tg, " grant"}, i2c_grant, VECS[i].g);
                check({tg, " refuse"}, i2c_refuse, VECS[i].r);
                check({tg, " region"}, i2c_region, VECS[i].rgn);
            end
            tick();
            sram_en = 1; vcc_ok = 1; field_ok = 1;
            release_all();
        end
        mode = 2'b00;
        tick();

        // R2 first come, plus R4 status during a lock, then R5 host clear
        i2c_req = 1; i2c_addr = 16'h0010; #5;
        check("R2 i2c grant", i2c_grant, 1);
        tick(); i2c_req = 0;
        check("R2 i2c locked", i2c_locked, 1);
        rf_req = 1; rf_blk = 8'h02; #5;
        check("R2 rf refused", rf_refuse, 1);
        tick(); rf_req = 0; #5;
        check("R2 rf lock stays clear", rf_locked, 0);
        rf_req = 1; rf_status = 1; #5;
        check("R4 rf status grant", rf_grant, 1);
        tick(); rf_req = 0; rf_status = 0; #5;
        check("R4 locks unchanged", {rf_locked, i2c_locked}, 1);
        i2c_clr_lock = 1; tick(); i2c_clr_lock = 0;
        check("R5 host clear", i2c_locked, 0);

        // R3 tie, then R8 release by command end and by field loss
        rf_req = 1; i2c_req = 1; rf_blk = 8'h01; i2c_addr = 16'h0001; #5;
        check("R3 tie rf grant", rf_grant, 1);
        check("R3 tie i2c refuse", i2c_refuse, 1);
        tick(); rf_req = 0; i2c_req = 0;
        check("R3 locks after tie", {rf_locked, i2c_locked}, 2);
        rf_done = 1; tick(); rf_done = 0;
        check("R8 rf_done release", rf_locked, 0);
        rf_req = 1; #5; tick(); rf_req = 0;
        check("R8 relocked", rf_locked, 1);
        field_ok = 0; tick(); field_ok = 1;
        check("R8 field loss release", rf_locked, 0);

        // R5 supply drop
        i2c_req = 1; i2c_addr = 16'h0003; #5; tick(); i2c_req = 0;
        vcc_ok = 0; tick(); vcc_ok = 1;
        check("R5 supply drop release", i2c_locked, 0);

        // R6 transaction end honoured only with the watchdog off
        wdg_en = 1; wdg_limit = 8'd200;
        i2c_req = 1; #5; tick(); i2c_req = 0;
        i2c_txn_end = 1; tick(); i2c_txn_end = 0;
        check("R6 txn end ignored with watchdog", i2c_locked, 1);
        wdg_en = 0;
        i2c_txn_end = 1; tick(); i2c_txn_end = 0;
        check("R6 txn end release", i2c_locked, 0);

        // R7 watchdog reload and expiry
        wdg_en = 1; wdg_limit = 8'd5;
        i2c_req = 1; #5; tick(); i2c_req = 0;
        tick(); tick(); tick();
        i2c_req = 1; #5;
        check("R7 reload grant", i2c_grant, 1);
        tick(); i2c_req = 0;
        tick(); tick(); tick(); tick();
        check("R7 no fire before limit", wdg_fire, 0);
        check("R7 locked before limit", i2c_locked, 1);
        tick();
        check("R7 fire at limit", wdg_fire, 1);
        check("R7 still locked at fire", i2c_locked, 1);
        tick();
        check("R7 lock freed", i2c_locked, 0);
        check("R7 single pulse", wdg_fire, 0);
        wdg_en = 0;

        // R12 refusal outside health mode
        mode = 2'b01;
        i2c_req = 1; i2c_addr = 16'h2000; #5; tick(); i2c_req = 0;
        rf_req = 1; rf_sram_cmd = 1; #5;
        check("R12 mirror refuses", rf_refuse, 1);
        tick();
        release_all();

        // R12 health-mode takeover
        mode = 2'b11;
        i2c_req = 1; i2c_addr = 16'h2000; #5;
        check("R12 i2c sram grant", i2c_grant, 1);
        tick(); i2c_req = 0;
        rf_req = 1; rf_sram_cmd = 1; #5;
        check("R12 waiting no grant", rf_grant, 0);
        check("R12 waiting no refuse", rf_refuse, 0);
        tick();
        i2c_byte_done = 1; #5;
        check("R12 byte edge no grant yet", rf_grant, 0);
        tick(); i2c_byte_done = 0; #5;
        check("R12 swapped locks", {rf_locked, i2c_locked}, 2);
        check("R12 stretch on", i2c_stretch, 1);
        check("R12 rf granted", rf_grant, 1);
        tick(); rf_req = 0; rf_sram_cmd = 0;
        rf_done = 1; tick(); rf_done = 0; #5;
        check("R12 locks restored", {rf_locked, i2c_locked}, 1);
        check("R12 stretch off", i2c_stretch, 0);
        release_all();
        tick();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule